// File: doc/BRIEF.md
# Sparse Quartic-Extension Multiplication Sequencer

The block multiplies a full element F = f0 + f1·u + f2·v + f3·uv of the degree-4 tower over GF(2^M) by a sparse element G = g0 + g1·u + v. It computes these products one at a time on a single external GF(2^M) multiplier. The tower rules are u² = u + 1 and v² = v + u, in the basis {1, u, v, uv}. G has only two free coefficients. Its v coefficient is fixed at one and its uv coefficient at zero. As a result the whole product needs just six base-field multiplications instead of the sixteen a dense product would need.

A start strobe captures the six input coefficients. The sequencer then issues the six multiplications back to back over a start/done port. Each returned product goes alternately into one of two result registers. The XOR recombination that belongs to a product runs in the cycle after that product is captured, while the next multiplication is still in flight. Only the final recombination costs an extra cycle. The four output coefficients are published with a one-cycle done pulse and are held until the next accepted start.

Top module: `ext4_sparse_mul`

## Requirements
- R1: While reset is held and after it is released, done and mul_start are 0 and all four output coefficients are 0.
- R2: With inputs f0..f3 and g0, g1, the outputs satisfy out0 + out1·u + out2·v + out3·uv = F·G, where G = g0 + g1·u + v, u² = u + 1 and v² = v + u. Addition is XOR and multiplication is the GF(2^M) product returned on mul_p.
- R3: Each accepted start causes exactly six mul_start pulses, and none while idle. The operand pairs appear on (mul_a, mul_b) in this order: (f0,g0), (f1,g1), (f0+f1, g0+g1), (f2,g0), (f3,g1), (f2+f3, g0+g1).
- R4: The second to sixth mul_start pulses occur in the same cycle as the mul_done of the previous product. No multiplication is ever started while another is outstanding and not returning.
- R5: With a multiplier that raises mul_done exactly LAT cycles after its mul_start cycle, done is high for exactly one cycle, 6·LAT + 3 cycles after the cycle in which start was accepted.
- R6: A start raised while an operation is in progress is ignored. The running result, its timing and the number of issued multiplications are unchanged, and no further done pulse follows.
- R7: The coefficients are sampled only in the cycle start is accepted. Changing f*_in or g*_in afterwards does not change the result.
- R8: Once done has been given, the outputs stay constant and no mul_start is issued until the next start, whatever the data inputs do.
- R9: A start raised in the cycle done is high is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new product; accepted when idle |
| f0_in | input | M | F coefficient of 1 |
| f1_in | input | M | F coefficient of u |
| f2_in | input | M | F coefficient of v |
| f3_in | input | M | F coefficient of uv |
| g0_in | input | M | G coefficient of 1 |
| g1_in | input | M | G coefficient of u |
| done | output | 1 | One-cycle pulse: outputs valid |
| out0 | output | M | Result coefficient of 1 |
| out1 | output | M | Result coefficient of u |
| out2 | output | M | Result coefficient of v |
| out3 | output | M | Result coefficient of uv |
| mul_start | output | 1 | Start pulse to the shared multiplier |
| mul_a | output | M | Multiplier operand A, valid with mul_start |
| mul_b | output | M | Multiplier operand B, valid with mul_start |
| mul_done | input | 1 | Multiplier result valid |
| mul_p | input | M | Multiplier product |

## Verification
The bench attacks the places where the overlapped schedule can go wrong:
- Back-to-back issue on the done cycle. A design that waited one cycle after each return would show a latency above 6·LAT + 3.
- The alternating result registers. A wrong bank choice would overwrite the first product before its second use and corrupt out1 or out3.
- G equal to plain v and all-ones operands. These expose a missing u or v reduction term.
- Starts raised mid-operation, and inputs changed after the start. A design that re-latched would produce a mixed result or an extra done.
- A start placed exactly on the done cycle. A design that cleared its busy state one cycle late would drop this operation.

// File: rtl/ext4_pkg.sv
// Shared definitions for the sparse quartic-extension multiplier.
// Assumes nothing beyond the fixed six-multiplication schedule.
package ext4_pkg;

    // Number of base-field products per sparse extension product.
    localparam int NUM_MUL = 6;

    // Width of counters that run from 0 to NUM_MUL inclusive.
    localparam int CNT_W = $clog2(NUM_MUL + 1);

    // Recombination step: names the product that was captured last cycle.
    typedef enum logic [CNT_W-1:0] {
        STEP_NONE = 3'd0,
        STEP_P1   = 3'd1,
        STEP_P2   = 3'd2,
        STEP_P3   = 3'd3,
        STEP_P4   = 3'd4,
        STEP_P5   = 3'd5,
        STEP_P6   = 3'd6
    } step_e;

endpackage

// File: rtl/ext4_sparse_ctrl.sv
// Issue/capture controller for the six-product schedule.
// Accepts a start only when idle. Issues the first product one cycle after
// acceptance and every later one in the cycle the previous product returns.
// Reports which product was captured, so the recombination can follow one
// cycle later. Assumes the multiplier raises mul_done once per mul_start.
module ext4_sparse_ctrl
    import ext4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mul_done,
    output logic             accept,
    output logic             busy,
    output logic             mul_start,
    output logic [CNT_W-1:0] sel,
    output logic             capture,
    output logic             bank,
    output step_e            step,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_MUL);

    logic             busy_q;
    logic             kick_q;
    logic             infl_q;
    logic             done_q;
    logic [CNT_W-1:0] nxt_q;
    logic [CNT_W-1:0] ncap_q;
    step_e            step_q;
    logic             issue;

    assign accept  = start & ~busy_q;
    assign capture = busy_q & infl_q & mul_done;
    assign issue   = kick_q | (capture & (nxt_q != LAST));

    // Busy from acceptance until the final recombination step executes.
    always_ff @(posedge clk) begin
        if (!rst_n)                 busy_q <= 1'b0;
        else if (accept)            busy_q <= 1'b1;
        else if (step_q == STEP_P6) busy_q <= 1'b0;
    end

    // One-cycle kick that launches the first product.
    always_ff @(posedge clk) begin
        if (!rst_n) kick_q <= 1'b0;
        else        kick_q <= accept;
    end

    // Tracks whether a product is outstanding at the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n)       infl_q <= 1'b0;
        else if (issue)   infl_q <= 1'b1;
        else if (capture) infl_q <= 1'b0;
    end

    // Index of the next product to issue.
    always_ff @(posedge clk) begin
        if (!rst_n)      nxt_q <= '0;
        else if (accept) nxt_q <= '0;
        else if (issue)  nxt_q <= nxt_q + 1'b1;
    end

    // Number of products captured so far; its LSB selects the result bank.
    always_ff @(posedge clk) begin
        if (!rst_n)       ncap_q <= '0;
        else if (accept)  ncap_q <= '0;
        else if (capture) ncap_q <= ncap_q + 1'b1;
    end

    // Recombination step for the cycle after a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       step_q <= STEP_NONE;
        else if (capture) step_q <= step_e'(ncap_q + 1'b1);
        else              step_q <= STEP_NONE;
    end

    // Done pulse follows the final recombination.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (step_q == STEP_P6);
    end

    assign busy      = busy_q;
    assign mul_start = issue;
    assign sel       = nxt_q;
    assign bank      = ncap_q[0];
    assign step      = step_q;
    assign done      = done_q;

    AST_RESTART_ONLY_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_start && infl_q) |-> mul_done);                           // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R5
    AST_SIX_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == STEP_P6) |-> (nxt_q == LAST));                      // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !mul_start);                                       // R3

endmodule

// File: rtl/ext4_sparse_opsel.sv
// Operand selector for the shared multiplier.
// Forms the two cross sums and presents operand pair number `sel` in the
// fixed order f0g0, f1g1, (f0+f1)(g0+g1), f2g0, f3g1, (f2+f3)(g0+g1).
// Assumes the coefficients stay stable for the whole operation.
module ext4_sparse_opsel
    import ext4_pkg::*;
#(
    parameter int M = 1223
) (
    input  logic [M-1:0]     f0,
    input  logic [M-1:0]     f1,
    input  logic [M-1:0]     f2,
    input  logic [M-1:0]     f3,
    input  logic [M-1:0]     g0,
    input  logic [M-1:0]     g1,
    input  logic [CNT_W-1:0] sel,
    output logic [M-1:0]     op_a,
    output logic [M-1:0]     op_b
);

    logic [M-1:0] cand_a [NUM_MUL];
    logic [M-1:0] cand_b [NUM_MUL];
    logic [M-1:0] gsum;

    assign gsum = g0 ^ g1;

    // The schedule splits into two halves of three, for the A and B pairs.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [M-1:0] lo;
        logic [M-1:0] hi;
        assign lo = (h == 0) ? f0 : f2;
        assign hi = (h == 0) ? f1 : f3;
        assign cand_a[3*h]     = lo;
        assign cand_b[3*h]     = g0;
        assign cand_a[3*h + 1] = hi;
        assign cand_b[3*h + 1] = g1;
        assign cand_a[3*h + 2] = lo ^ hi;
        assign cand_b[3*h + 2] = gsum;
    end

    // AND-OR selection of the current pair; zero once the schedule is spent.
    always_comb begin
        op_a = '0;
        op_b = '0;
        for (int k = 0; k < NUM_MUL; k++) begin
            if (sel == CNT_W'(k)) begin
                op_a = op_a | cand_a[k];
                op_b = op_b | cand_b[k];
            end
        end
    end

endmodule

// File: rtl/ext4_sparse_acc.sv
// Result banks and XOR recombination.
// Products alternate between bank 0 (products 1,3,5) and bank 1 (2,4,6).
// In the cycle after each capture the matching partial sums are folded into
// the output registers, so no product is needed after its bank is reused.
// Assumes `step` names the product captured at the previous edge.
module ext4_sparse_acc
    import ext4_pkg::*;
#(
    parameter int M = 1223
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         bank,
    input  logic [M-1:0] mul_p,
    input  step_e        step,
    input  logic [M-1:0] f0,
    input  logic [M-1:0] f1,
    input  logic [M-1:0] f2,
    input  logic [M-1:0] f3,
    output logic [M-1:0] out0,
    output logic [M-1:0] out1,
    output logic [M-1:0] out2,
    output logic [M-1:0] out3
);

    logic [M-1:0] r0_q, r1_q;
    logic [M-1:0] o0_q, o1_q, o2_q, o3_q;

    // Capture the returning product into the bank picked by capture parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r0_q <= '0;
            r1_q <= '0;
        end else if (capture) begin
            if (!bank) r0_q <= mul_p;
            else       r1_q <= mul_p;
        end
    end

    // Fold banked products into the four output coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o0_q <= '0;
            o1_q <= '0;
            o2_q <= '0;
            o3_q <= '0;
        end else begin
            case (step)
                STEP_P2: begin
                    o0_q <= r0_q ^ r1_q ^ f3;
                    o1_q <= r0_q ^ f2 ^ f3;
                end
                STEP_P3: o1_q <= o1_q ^ r0_q;
                STEP_P4: begin
                    o2_q <= f0 ^ f2 ^ r1_q;
                    o3_q <= f1 ^ f3 ^ r1_q;
                end
                STEP_P5: o2_q <= o2_q ^ r0_q;
                STEP_P6: o3_q <= o3_q ^ r1_q;
                default: ;
            endcase
        end
    end

    assign out0 = o0_q;
    assign out1 = o1_q;
    assign out2 = o2_q;
    assign out3 = o3_q;

    AST_BANK_STEADY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(r0_q) && $stable(r1_q)));                // R2

endmodule

// File: rtl/ext4_sparse_mul.sv
// Sparse quartic-extension multiplier: F * (g0 + g1 u + v) over GF(2^M),
// tower u^2 = u + 1, v^2 = v + u, basis {1, u, v, uv}.
// Uses one external fixed-latency multiplier through a start/done port.
// mul_a and mul_b are valid only in the cycle mul_start is high.
// Assumes every mul_start is answered by exactly one mul_done.
module ext4_sparse_mul
    import ext4_pkg::*;
#(
    parameter int M = 1223
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] f0_in,
    input  logic [M-1:0] f1_in,
    input  logic [M-1:0] f2_in,
    input  logic [M-1:0] f3_in,
    input  logic [M-1:0] g0_in,
    input  logic [M-1:0] g1_in,
    output logic         done,
    output logic [M-1:0] out0,
    output logic [M-1:0] out1,
    output logic [M-1:0] out2,
    output logic [M-1:0] out3,
    output logic         mul_start,
    output logic [M-1:0] mul_a,
    output logic [M-1:0] mul_b,
    input  logic         mul_done,
    input  logic [M-1:0] mul_p
);

    logic             accept;
    logic             busy;
    logic [CNT_W-1:0] sel;
    logic             capture;
    logic             bank;
    step_e            step;
    logic [M-1:0]     lf0, lf1, lf2, lf3, lg0, lg1;

    // Sample the operand coefficients in the cycle a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lf0 <= '0; lf1 <= '0; lf2 <= '0; lf3 <= '0;
            lg0 <= '0; lg1 <= '0;
        end else if (accept) begin
            lf0 <= f0_in; lf1 <= f1_in; lf2 <= f2_in; lf3 <= f3_in;
            lg0 <= g0_in; lg1 <= g1_in;
        end
    end

    ext4_sparse_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mul_done  (mul_done),
        .accept    (accept),
        .busy      (busy),
        .mul_start (mul_start),
        .sel       (sel),
        .capture   (capture),
        .bank      (bank),
        .step      (step),
        .done      (done)
    );

    ext4_sparse_opsel #(.M(M)) i_opsel (
        .f0   (lf0),
        .f1   (lf1),
        .f2   (lf2),
        .f3   (lf3),
        .g0   (lg0),
        .g1   (lg1),
        .sel  (sel),
        .op_a (mul_a),
        .op_b (mul_b)
    );

    ext4_sparse_acc #(.M(M)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .bank    (bank),
        .mul_p   (mul_p),
        .step    (step),
        .f0      (lf0),
        .f1      (lf1),
        .f2      (lf2),
        .f3      (lf3),
        .out0    (out0),
        .out1    (out1),
        .out2    (out2),
        .out3    (out3)
    );

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({lf0, lf1, lf2, lf3, lg0, lg1}));             // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({out0, out1, out2, out3}));      // R8

endmodule

// File: tb/test_ext4_sparse_mul.sv
module test_ext4_sparse_mul;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int M   = 8;
    localparam int LAT = 4;
    localparam logic [M-1:0] POLY = 8'h1B;   // x^8 + x^4 + x^3 + x + 1
    localparam int EXP_LAT = 6 * LAT + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [M-1:0] fi0 = '0, fi1 = '0, fi2 = '0, fi3 = '0, gi0 = '0, gi1 = '0;
    logic done;
    logic [M-1:0] out0, out1, out2, out3;
    logic mul_start, mul_done;
    logic [M-1:0] mul_a, mul_b, mul_p;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_iss = 0;
    int b2b = 0;
    int s_cyc = 0;
    logic [M-1:0] log_a [8];
    logic [M-1:0] log_b [8];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ext4_sparse_mul #(.M(M)) i_ext4_sparse_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .f0_in(fi0), .f1_in(fi1), .f2_in(fi2), .f3_in(fi3),
        .g0_in(gi0), .g1_in(gi1),
        .done(done), .out0(out0), .out1(out1), .out2(out2), .out3(out3),
        .mul_start(mul_start), .mul_a(mul_a), .mul_b(mul_b),
        .mul_done(mul_done), .mul_p(mul_p)
    );

    function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc = '0;
        logic [M-1:0] sh = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[M-1] ? ((sh << 1) ^ POLY) : (sh << 1);
        end
        return acc;
    endfunction

    // Schoolbook product in GF(2^M)[u]/(u^2+u+1); returns {coef_u, coef_1}.
    function automatic logic [2*M-1:0] q_mul(input logic [M-1:0] a0, a1, c0, c1);
        logic [M-1:0] t11 = gf_mul(a1, c1);
        return {gf_mul(a0, c1) ^ gf_mul(a1, c0) ^ t11, gf_mul(a0, c0) ^ t11};
    endfunction

    // (A + B v)(C + D v) with v^2 = v + u; D = 1 for the sparse operand.
    function automatic logic [4*M-1:0] ref_prod(input logic [M-1:0] f0, f1, f2, f3, g0, g1);
        logic [2*M-1:0] ac = q_mul(f0, f1, g0, g1);
        logic [2*M-1:0] ad = q_mul(f0, f1, 8'h01, 8'h00);
        logic [2*M-1:0] bc = q_mul(f2, f3, g0, g1);
        logic [2*M-1:0] bd = q_mul(f2, f3, 8'h01, 8'h00);
        logic [2*M-1:0] bdu = q_mul(bd[M-1:0], bd[2*M-1:M], 8'h00, 8'h01);
        logic [2*M-1:0] lo = ac ^ bdu;
        logic [2*M-1:0] hi = ad ^ bc ^ bd;
        return {hi, lo};
    endfunction

    // Behavioural multiplier answering LAT cycles after its start cycle.
    logic m_busy = 1'b0;
    int   m_cnt = 0;
    logic [M-1:0] m_p = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_cnt <= 0; m_p <= '0;
        end else if (mul_start) begin
            m_busy <= 1'b1; m_cnt <= 1; m_p <= gf_mul(mul_a, mul_b);
            if (n_iss < 8) begin
                log_a[n_iss] <= mul_a;
                log_b[n_iss] <= mul_b;
            end
            n_iss <= n_iss + 1;
            if (mul_done) b2b <= b2b + 1;
        end else if (mul_done) begin
            m_busy <= 1'b0;
        end else if (m_busy) begin
            m_cnt <= m_cnt + 1;
        end
    end
    assign mul_done = m_busy && (m_cnt == LAT);
    assign mul_p    = m_p;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_ops(input logic [M-1:0] f0, f1, f2, f3, g0, g1);
        fi0 = f0; fi1 = f1; fi2 = f2; fi3 = f3; gi0 = g0; gi1 = g1;
    endtask

    // Start an operation at a negedge; start is high for this one cycle.
    task automatic launch(input logic [M-1:0] f0, f1, f2, f3, g0, g1);
        @(negedge clk);
        drive_ops(f0, f1, f2, f3, g0, g1);
        start = 1'b1;
        s_cyc = cyc;
        n_iss = 0;
        b2b = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done at negedges; returns cycles since the start cycle.
    task automatic wait_done(output int lat);
        int w = 0;
        while (!done && w < 400) begin
            @(negedge clk);
            w++;
        end
        lat = cyc - s_cyc;
        chk(done, "R5", "done seen before timeout", 64'(done), 64'd1);
    endtask

    // Checks on a completed operation: result, issue order, overlap, timing.
    task automatic check_op(input logic [M-1:0] f0, f1, f2, f3, g0, g1, input int lat);
        logic [4*M-1:0] exp = ref_prod(f0, f1, f2, f3, g0, g1);
        logic [M-1:0] ea [6];
        logic [M-1:0] eb [6];
        ea = '{f0, f1, f0 ^ f1, f2, f3, f2 ^ f3};
        eb = '{g0, g1, g0 ^ g1, g0, g1, g0 ^ g1};
        chk({out3, out2, out1, out0} == exp, "R2", "product coefficients",
            64'({out3, out2, out1, out0}), 64'(exp));
        chk(lat == EXP_LAT, "R5", "done latency", 64'(lat), 64'(EXP_LAT));
        chk(n_iss == 6, "R3", "multiplications issued", 64'(n_iss), 64'd6);
        for (int k = 0; k < 6; k++) begin
            chk(log_a[k] == ea[k] && log_b[k] == eb[k], "R3", "operand pair order",
                64'({log_a[k], log_b[k]}), 64'({ea[k], eb[k]}));
        end
        chk(b2b == 5, "R4", "issues on the return cycle", 64'(b2b), 64'd5);
        @(negedge clk);
        chk(!done, "R5", "done width one cycle", 64'(done), 64'd0);
    endtask

    task automatic full_op(input logic [M-1:0] f0, f1, f2, f3, g0, g1);
        int lat;
        launch(f0, f1, f2, f3, g0, g1);
        wait_done(lat);
        check_op(f0, f1, f2, f3, g0, g1, lat);
    endtask

    task automatic t_reset();
        chk(!done && !mul_start, "R1", "control outputs in reset", 64'({done, mul_start}), 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mul_start, "R1", "control outputs after reset", 64'({done, mul_start}), 64'd0);
        chk({out3, out2, out1, out0} == '0, "R1", "outputs after reset",
            64'({out3, out2, out1, out0}), 64'd0);
    endtask

    task automatic t_patterns();
        full_op(8'h57, 8'h83, 8'h1F, 8'hC4, 8'h2A, 8'h91);   // R2 mixed
        full_op(8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h00);   // R2 G = v
        full_op(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);   // R2 all ones
        full_op(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);   // R2 uv * (1+v)
        for (int n = 0; n < 4; n++) begin
            full_op(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                    8'($urandom), 8'($urandom));
        end
    endtask

    task automatic t_busy_start();
        int lat;
        int extra = 0;
        launch(8'hA5, 8'h3C, 8'h69, 8'hF0, 8'h0E, 8'h77);
        repeat (LAT + 3) @(negedge clk);
        drive_ops(8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check_op(8'hA5, 8'h3C, 8'h69, 8'hF0, 8'h0E, 8'h77, lat);   // R6
        for (int k = 0; k < EXP_LAT + 4; k++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R6", "no done from ignored start", 64'(extra), 64'd0);
        chk(n_iss == 6, "R6", "no issue from ignored start", 64'(n_iss), 64'd6);
    endtask

    task automatic t_input_change();
        int lat;
        launch(8'h0F, 8'hB2, 8'h4D, 8'h9E, 8'hC3, 8'h18);
        drive_ops(8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00);
        wait_done(lat);
        check_op(8'h0F, 8'hB2, 8'h4D, 8'h9E, 8'hC3, 8'h18, lat);   // R7
    endtask

    task automatic t_hold();
        logic [4*M-1:0] held;
        int issues = 0;
        int moved = 0;
        full_op(8'h6B, 8'h21, 8'hD8, 8'h05, 8'hE7, 8'h3A);
        held = {out3, out2, out1, out0};
        for (int k = 0; k < 20; k++) begin
            drive_ops(8'(k * 13), 8'(k * 7), 8'(k + 99), 8'(k ^ 8'h5A), 8'(k * 3), 8'(~k));
            @(negedge clk);
            if (mul_start) issues++;
            if ({out3, out2, out1, out0} != held) moved++;
        end
        chk(moved == 0, "R8", "outputs held while idle", 64'(moved), 64'd0);
        chk(issues == 0, "R8", "no multiplier start while idle", 64'(issues), 64'd0);
    endtask

    task automatic t_back_to_back();
        int lat;
        launch(8'h44, 8'h99, 8'h2C, 8'hE1, 8'h7B, 8'h50);
        wait_done(lat);
        chk({out3, out2, out1, out0} == ref_prod(8'h44, 8'h99, 8'h2C, 8'hE1, 8'h7B, 8'h50),
            "R9", "first of back-to-back pair", 64'({out3, out2, out1, out0}),
            64'(ref_prod(8'h44, 8'h99, 8'h2C, 8'hE1, 8'h7B, 8'h50)));
        drive_ops(8'hC8, 8'h17, 8'hFE, 8'h63, 8'h8D, 8'hB4);
        start = 1'b1;
        s_cyc = cyc;
        n_iss = 0;
        b2b = 0;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk(lat == EXP_LAT, "R9", "start on done cycle accepted", 64'(lat), 64'(EXP_LAT));
        check_op(8'hC8, 8'h17, 8'hFE, 8'h63, 8'h8D, 8'hB4, lat);
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_busy_start();
        t_input_change();
        t_hold();
        t_back_to_back();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule